// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block picks which of a set of interrupt requests goes to the CPU next. It also decides whether that request may interrupt the handler that is already running. Each interrupt has a 4-bit priority value, giving 16 levels, and a lower value is more urgent. A global split setting divides that value into two parts. The upper part is the group level and the lower part is the subpriority. When the split gives all four bits to the group, the block runs in plain level mode.

Among the interrupts that are both pending and enabled, the one with the smallest priority value wins. Equal values go to the lowest interrupt number. Comparing the whole value works because it orders requests by group, then by subpriority, then by number.

Only the group level decides preemption. A request whose group level is equal to or worse than the running handler's level waits. It waits even when its interrupt number is lower. The block keeps a stack of the group levels that are active, so handlers can nest. Each accepted request pushes its level, and each end-of-handler pulse pops one entry.

The request to the CPU is a valid/ready pair. `take_valid` and `take_id` are combinational views of the current inputs. They may change or drop while `take_ready` is low, and nothing is latched until a cycle with both signals high. The CPU may hold `take_ready` low for as long as it likes, and the arbiter's state does not change while it does. Pending bits belong to the interrupt sources. The arbiter never clears them, so a disabled pending request still shows its pending bit at the input.

Top module: `irq_nest_arbiter`

## Requirements
- R1: After reset the stack is empty: `active_depth` is 0, `active_level` reads 15, and with no request pending `take_valid` is 0.
- R2: An interrupt is eligible only when both its pending and its enable bit are 1. An interrupt that is pending but disabled is never selected, and it has no effect on `take_valid`.
- R3: `take_id` names the eligible interrupt with the numerically smallest 4-bit priority value.
- R4: Among eligible interrupts with equal priority values, the lowest interrupt number is selected.
- R5: With an empty stack, outside a cycle with `handler_done`, `take_valid` is 1 whenever any interrupt is eligible.
- R6: With a non-empty stack, `take_valid` is 1 only if the winner's group level is strictly smaller than `active_level`. A winner at the same group level never preempts, whatever its interrupt number.
- R7: `group_bits` gives g group bits, where g is `group_bits`, and values above 4 count as 4. The group level is the priority value with its low 4-g bits forced to zero, and `take_level` reports that level. With g=0 every request has group level 0, so nothing can preempt an active handler.
- R8: In a cycle with `take_valid` and `take_ready` both high, the stack pushes `take_level`. On the next cycle `active_depth` has risen by one and `active_level` equals the pushed level.
- R9: `handler_done` pops one entry when the stack is not empty, and `active_level` returns to the level below it. A `handler_done` pulse with an empty stack has no effect.
- R10: The stack holds STACK_DEPTH entries (4 by default). While it is full, `take_valid` is 0.
- R11: In a cycle with `handler_done` high, `take_valid` is 0, so no push and pop happen together.
- R12: Without an accepted take and without `handler_done`, `active_depth` and `active_level` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pending | input | NUM_IRQ | Pending bit per interrupt |
| irq_enable | input | NUM_IRQ | Enable bit per interrupt |
| irq_prio | input | 4*NUM_IRQ | Priority value per interrupt; interrupt i uses bits [4i+3:4i] |
| group_bits | input | 3 | Number of group bits in the priority value (0 to 4; larger values count as 4) |
| take_ready | input | 1 | The CPU accepts the offered interrupt |
| handler_done | input | 1 | The innermost active handler has finished |
| take_valid | output | 1 | The offered interrupt may be taken now |
| take_id | output | $clog2(NUM_IRQ) | Number of the offered interrupt |
| take_level | output | 4 | Group level of the offered interrupt |
| active_level | output | 4 | Group level on top of the stack, or 15 when the stack is empty |
| active_depth | output | $clog2(STACK_DEPTH+1) | Number of nested active handlers |

## Verification
The assertions assume that `group_bits` changes only while the stack is empty. Changing it while handlers are active would make the stored levels disagree with the current split. The bench respects this by changing the split only when its model stack is empty. The assertions also assume that `handler_done` comes only from a CPU that is running a handler. The bench still sends some pulses with an empty stack to show that they are ignored. The stimulus mixes random pending, enable, ready and done patterns with directed sequences for ties, same-level blocking, split widths and a full stack.

// File: rtl/irq_nest_arbiter_pkg.sv
package irq_nest_arbiter_pkg;
  localparam int unsigned PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;

  // Clear the subpriority bits, keeping the top g bits (g saturates at PRIO_W)
  function automatic prio_t group_mask(input logic [2:0] gbits);
    int unsigned g;
    g = (int'(gbits) > PRIO_W) ? PRIO_W : int'(gbits);
    return prio_t'(({PRIO_W{1'b1}} << (PRIO_W - g)));
  endfunction
endpackage

// File: rtl/irq_nest_select.sv
module irq_nest_select
  import irq_nest_arbiter_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned IW = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]        eligible,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic                      found,
  output logic [IW-1:0]             best_id,
  output prio_t                     best_prio
);
  // Strict less-than keeps the earliest index on equal values
  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (eligible[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
        found     = 1'b1;
        best_id   = IW'(i);
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_nest_arbiter_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 4,
  localparam int unsigned DW = $clog2(STACK_DEPTH + 1),
  localparam int unsigned AW = $clog2(STACK_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  prio_t         push_level,
  output prio_t         top_level,
  output logic [DW-1:0] depth,
  output logic          empty,
  output logic          full
);
  prio_t mem [STACK_DEPTH];

  assign empty     = (depth == '0);
  assign full      = (depth == DW'(STACK_DEPTH));
  assign top_level = empty ? '1 : mem[AW'(depth - DW'(1))];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (pop && !empty) begin
      depth <= depth - DW'(1);
    end else if (push && !full) begin
      mem[AW'(depth)] <= push_level;
      depth           <= depth + DW'(1);
    end
  end
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
  import irq_nest_arbiter_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 8,
  parameter int unsigned STACK_DEPTH = 4,
  localparam int unsigned IW = $clog2(NUM_IRQ),
  localparam int unsigned DW = $clog2(STACK_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_pending,
  input  logic [NUM_IRQ-1:0]        irq_enable,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [2:0]                group_bits,
  input  logic                      take_ready,
  input  logic                      handler_done,
  output logic                      take_valid,
  output logic [IW-1:0]             take_id,
  output logic [PRIO_W-1:0]         take_level,
  output logic [PRIO_W-1:0]         active_level,
  output logic [DW-1:0]             active_depth
);
  logic [NUM_IRQ-1:0] eligible;
  logic               found;
  prio_t              best_prio;
  prio_t              cur_level;
  logic               stk_empty;
  logic               stk_full;

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_elig
    assign eligible[gi] = irq_pending[gi] & irq_enable[gi];
  end

  irq_nest_select #(.NUM_IRQ(NUM_IRQ)) u_select (
    .eligible  (eligible),
    .prio_flat (irq_prio),
    .found     (found),
    .best_id   (take_id),
    .best_prio (best_prio)
  );

  assign take_level = best_prio & group_mask(group_bits);

  // Preempt only on a strictly better group level
  assign take_valid = found && !handler_done && !stk_full &&
                      (stk_empty || (take_level < cur_level));

  irq_nest_stack #(.STACK_DEPTH(STACK_DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (take_valid && take_ready),
    .pop        (handler_done),
    .push_level (take_level),
    .top_level  (cur_level),
    .depth      (active_depth),
    .empty      (stk_empty),
    .full       (stk_full)
  );

  assign active_level = cur_level;
endmodule

// File: rtl/irq_nest_arbiter_sva.sv
module irq_nest_arbiter_sva #(
  parameter int unsigned NUM_IRQ     = 8,
  parameter int unsigned STACK_DEPTH = 4,
  localparam int unsigned IW = $clog2(NUM_IRQ),
  localparam int unsigned DW = $clog2(STACK_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_IRQ-1:0]   irq_pending,
  input logic [NUM_IRQ-1:0]   irq_enable,
  input logic [NUM_IRQ*4-1:0] irq_prio,
  input logic [2:0]           group_bits,
  input logic                 take_ready,
  input logic                 handler_done,
  input logic                 take_valid,
  input logic [IW-1:0]        take_id,
  input logic [3:0]           take_level,
  input logic [3:0]           active_level,
  input logic [DW-1:0]        active_depth
);
  p_eligible_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (irq_pending[take_id] && irq_enable[take_id]));

  p_idle_offers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_depth == '0 && |(irq_pending & irq_enable) && !handler_done) |-> take_valid);

  p_strict_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && active_depth != '0) |-> (take_level < active_level));

  p_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_ready) |=>
      (active_depth == $past(active_depth) + DW'(1) && active_level == $past(take_level)));

  p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_done && active_depth != '0) |=> active_depth == $past(active_depth) - DW'(1));

  p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_depth == DW'(STACK_DEPTH)) |-> !take_valid);

  p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active_depth <= DW'(STACK_DEPTH));

  p_done_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    handler_done |-> !take_valid);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!(take_valid && take_ready) && !handler_done) |=>
      ($stable(active_depth) && $stable(active_level)));
endmodule

bind irq_nest_arbiter irq_nest_arbiter_sva #(
  .NUM_IRQ(NUM_IRQ), .STACK_DEPTH(STACK_DEPTH)
) u_sva (.*);

// File: tb/irq_nest_arbiter_test.sv
module irq_nest_arbiter_test;
  localparam int N = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pend = '0;
  logic [N-1:0] en = '0;
  logic [N*4-1:0] prio = '0;
  logic [2:0]   gb = 3'd4;
  logic         rdy = 1'b0;
  logic         done = 1'b0;
  logic         take_valid;
  logic [2:0]   take_id;
  logic [3:0]   take_level;
  logic [3:0]   active_level;
  logic [2:0]   active_depth;

  int errors = 0;
  int checks = 0;
  logic [3:0] mstk [D];
  int mdep = 0;

  always #4 clk = ~clk;

  irq_nest_arbiter #(.NUM_IRQ(N), .STACK_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .irq_pending(pend), .irq_enable(en),
    .irq_prio(prio), .group_bits(gb), .take_ready(rdy), .handler_done(done),
    .take_valid(take_valid), .take_id(take_id), .take_level(take_level),
    .active_level(active_level), .active_depth(active_depth)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] mask_of(input logic [2:0] g);
    int gg;
    gg = (g > 3'd4) ? 4 : int'(g);
    return 4'(4'hF << (4 - gg));
  endfunction

  task automatic setp(input int i, input logic [3:0] v);
    prio[i*4 +: 4] = v;
  endtask

  // Check the outputs against the model for the current inputs, then advance one cycle
  task automatic step(input string tag);
    logic any; int bid; logic [3:0] bp; logic [3:0] lvl; logic ev; logic [3:0] top;
    #2;
    any = 1'b0; bid = 0; bp = 4'hF;
    for (int i = 0; i < N; i++)
      if (pend[i] && en[i] && (!any || prio[i*4 +: 4] < bp)) begin
        any = 1'b1; bid = i; bp = prio[i*4 +: 4];
      end
    lvl = bp & mask_of(gb);
    top = (mdep == 0) ? 4'hF : mstk[mdep-1];
    ev  = any && !done && (mdep < D) && (mdep == 0 || lvl < top);
    chk(tag, "take_valid", int'(take_valid), int'(ev));
    if (ev) begin
      chk(tag, "take_id", int'(take_id), bid);
      chk(tag, "take_level", int'(take_level), int'(lvl));
    end
    chk(tag, "active_depth", int'(active_depth), mdep);
    chk(tag, "active_level", int'(active_level), int'(top));
    if (done) begin
      if (mdep > 0) mdep--;
    end else if (ev && rdy) begin
      mstk[mdep] = lvl; mdep++;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1");

    // R2: pending but disabled ignored
    pend = 8'hFF; en = 8'h00; for (int i = 0; i < N; i++) setp(i, 4'(i));
    step("R2");
    en = 8'b0010_0000; step("R2");
    // R3: smallest value wins
    setp(6, 4'd2); setp(3, 4'd9); en = 8'hFF; setp(0, 4'd7); setp(1, 4'd8); setp(2, 4'd5);
    setp(4, 4'd11); setp(5, 4'd12); setp(7, 4'd3); step("R3");
    // R4 tie, R12 no ready
    for (int i = 0; i < N; i++) setp(i, 4'd3);
    pend = 8'b0110_1000; step("R4"); step("R12");
    // R5/R6 plain mode nesting
    gb = 3'd4; pend = 8'b0010_0000; setp(5, 4'd6); rdy = 1'b1; step("R5");
    pend = 8'b0000_0010; setp(1, 4'd6); step("R6");
    pend = 8'b0000_0100; setp(2, 4'd5); step("R6");
    rdy = 1'b0; pend = '0; done = 1'b1; step("R9"); step("R9"); step("R9");
    done = 1'b0;
    // R7: two group bits, then zero
    gb = 3'd2; rdy = 1'b1; pend = 8'b1000_0000; setp(7, 4'd5); step("R7");
    pend = 8'b0000_0001; setp(0, 4'd4); step("R7");
    setp(0, 4'd3); step("R7");
    pend = '0; done = 1'b1; step("R9"); step("R9"); done = 1'b0;
    gb = 3'd0; pend = 8'b0100_0000; setp(6, 4'd15); step("R7");
    pend = 8'b0000_0001; setp(0, 4'd0); step("R7");
    pend = '0; done = 1'b1; step("R9"); done = 1'b0;
    // R10: fill the stack
    gb = 3'd7; setp(0, 4'd9); setp(1, 4'd7); setp(2, 4'd5); setp(3, 4'd3); setp(4, 4'd0);
    for (int k = 0; k < 4; k++) begin pend = 8'(1 << k); step("R8"); end
    pend = 8'b0001_0000; step("R10"); step("R10");
    // R11: done blocks the offer
    done = 1'b1; step("R11");
    rdy = 1'b0; done = 1'b0; step("R10");
    pend = '0; done = 1'b1;
    for (int k = 0; k < 4; k++) step("R9");
    done = 1'b0;

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      pend = 8'($urandom); en = 8'($urandom);
      for (int i = 0; i < N; i++) setp(i, 4'($urandom));
      if (mdep == 0 && ($urandom % 8) == 0) gb = 3'($urandom);
      rdy  = (($urandom % 2) == 0);
      done = (($urandom % 5) == 0);
      step("R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule